// File: doc/BRIEF.md
# PLL Setting Search Engine

This block finds a PLL setting for a requested output frequency. Given a reference frequency and a target frequency, both unsigned integers in kHz, it walks every combination of a feedback multiplier, a one-bit pre-divider and a three-bit post-divider shift. It keeps the setting whose output comes closest to the target from below and stops early when one lands exactly on it. It then picks a loop-filter band code from the reference frequency after pre-division, expressed in whole MHz. The result is packed into a 32-bit configuration word, returned together with the frequency it achieves and three flags.

A caller pulses `start` with both frequencies valid on that cycle. The engine raises `busy` and later pulses `done` for one cycle. On that cycle the word, frequency and flags are valid, and they stay unchanged until the next search completes. The reference is first converted from kHz to MHz by a shift-and-subtract divider. The trial frequencies are then evaluated one per clock. The divisor in the trial formula is always a power of two, so the trial quotient is a right shift of a running product.

Top module: `pllsrch_engine`

## Requirements
- R1: For a setting (mul 0..255, pre 0..1, post 0..7) the output frequency is floor(ref × (mul+1) / ((pre+1) × 2^post)), and `freq_khz` equals this value for the reported setting.
- R2: Settings are visited with pre from 1 down to 0 (outermost), then post from 7 down to 0, then mul from 0 up to 255 (innermost). When several settings give the same smallest error, the first one visited is reported.
- R3: A setting whose frequency exceeds the target is never reported. Among the others, the one with the smallest target − frequency is reported.
- R4: When a setting hits the target exactly, the search stops there, that setting is reported and `exact` is 1. Otherwise `exact` is 0.
- R5: The filter code comes from m = floor(floor(ref/1000)/(pre+1)) for the reported pre. The code is 7 for m ≥ 166, 6 for m ≥ 104, 5 for m ≥ 65, 4 for m ≥ 42, 3 for m ≥ 26, 2 for m ≥ 16, 1 for m ≥ 10, and 0 below 10.
- R6: `range_warn` is 1 exactly when m (as in R5) is below 10 or above 200.
- R7: `cfg_word` carries the filter code in bits 31:24, mul in bits 23:16, pre in bit 8 and post in bits 2:0. All other bits are 0.
- R8: If every setting exceeds the target, `no_solution` is 1 and `cfg_word`, `freq_khz`, `exact` and `range_warn` are all 0.
- R9: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after an accepted start until `done` rises.
- R10: A start pulse while `busy` is high is ignored: it neither changes the running search nor produces an extra `done`.
- R11: After reset all outputs are 0. The result outputs hold their values from one `done` until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search with the present inputs |
| ref_khz | input | FREQ_W | Reference frequency in kHz |
| target_khz | input | FREQ_W | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_word | output | 32 | Packed PLL configuration |
| freq_khz | output | FREQ_W | Frequency the reported setting produces |
| exact | output | 1 | Target reached exactly |
| range_warn | output | 1 | Pre-divided reference outside 10..200 MHz |
| no_solution | output | 1 | Every setting overshoots the target |

## Verification
Targets are chosen so that several distinct outcomes occur. Some are exact multiples that end the search early in the first group able to reach them. Others are odd values that force a full walk, where ties between settings in different groups decide the reported setting. Others are too small for any setting and must give the all-zero no-solution result. References are spread across the filter bands and beyond both ends of the range warning, so that a wrong band edge or a wrong choice of pre for the band lookup shows up in the packed word. A start pulse issued in mid-search checks that only one result appears and that it belongs to the first request.

// File: rtl/pllsrch_pkg.sv
// Shared field widths, setting type, FSM encoding and word packing for
// the PLL setting search engine.
package pllsrch_pkg;

    localparam int MUL_W = 8;
    localparam int POST_W = 3;
    localparam int FLT_W = 3;

    localparam logic [MUL_W-1:0]  MUL_LAST  = '1;
    localparam logic [POST_W-1:0] POST_HIGH = '1;

    typedef struct packed {
        logic              pre;
        logic [POST_W-1:0] post;
        logic [MUL_W-1:0]  mul;
    } pll_set_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_SCAN,
        ST_WRAP
    } eng_state_t;

    // Place the filter code and the setting fields into the 32-bit word.
    function automatic logic [31:0] pack_cfg(logic [FLT_W-1:0] code, pll_set_t s);
        logic [31:0] w;
        w        = '0;
        w[31:24] = 8'(code);
        w[23:16] = s.mul;
        w[8]     = s.pre;
        w[2:0]   = s.post;
        return w;
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
// Restoring divider by a constant.
// Divides an unsigned W-bit dividend by DIVISOR, one quotient bit per
// cycle, W cycles per division. Assumes DIVISOR >= 1. The quotient and
// remainder stay valid after done until the next start.
module pllsrch_div #(
    parameter int W       = 24,
    parameter int DIVISOR = 1000,
    localparam int DW     = $clog2(DIVISOR + 1),
    localparam int CNT_W  = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  dividend,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  quotient,
    output logic [DW-1:0] remainder
);

    localparam logic [DW:0]   DV_EXT = (DW + 1)'(DIVISOR);
    localparam logic [W+DW-1:0] DV_WIDE = (W + DW)'(DIVISOR);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     quo_q;
    logic [DW-1:0]    rem_q;
    logic [W-1:0]     dvd_q;
    logic             busy_q;
    logic             done_q;
    logic [DW:0]      rem_sh;
    logic [DW:0]      rem_sub;

    // Shift the next dividend bit into the partial remainder and trial-subtract.
    always_comb begin
        rem_sh  = {rem_q, quo_q[W-1]};
        rem_sub = rem_sh - DV_EXT;
    end

    // One restoring step per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(W);
                quo_q  <= dividend;
                rem_q  <= '0;
                dvd_q  <= dividend;
            end else if (busy_q) begin
                if (rem_sh >= DV_EXT) begin
                    rem_q <= rem_sub[DW-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= rem_sh[DW-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R5: the MHz value fed to the band lookup is the true floor quotient.
    a_r5_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (((W + DW)'(quo_q) * DV_WIDE + (W + DW)'(rem_q)) == (W + DW)'(dvd_q))
                   && ((DW + 1)'(rem_q) < DV_EXT));

endmodule

// File: rtl/pllsrch_walker.sv
// Setting walker.
// Steps through every (pre, post, mul) setting in the required order and
// keeps a running product ref*(mul+1), so that no multiplier is needed.
// The trial frequency is that product shifted right by pre+post. A skip
// request abandons the rest of the current mul sweep. This is safe
// because the trial only grows with mul. 'last' marks the final step.
module pllsrch_walker
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W  = 24,
    localparam int ACC_W  = FREQ_W + MUL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              skip,
    input  logic [FREQ_W-1:0] ref_in,
    output pll_set_t          cur,
    output logic [ACC_W-1:0]  trial,
    output logic              last
);

    pll_set_t          cur_q;
    logic [ACC_W-1:0]  acc_q;
    logic [FREQ_W-1:0] ref_q;
    logic              sweep_end;
    logic [3:0]        shamt;

    // End of the current mul sweep, and end of the whole walk.
    always_comb begin
        sweep_end = skip || (cur_q.mul == MUL_LAST);
        last      = sweep_end && !cur_q.pre && (cur_q.post == '0);
        shamt     = 4'(cur_q.pre) + 4'(cur_q.post);
        trial     = acc_q >> shamt;
    end

    // Advance the setting and the running product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            acc_q <= '0;
            ref_q <= '0;
        end else if (load) begin
            ref_q      <= ref_in;
            acc_q      <= ACC_W'(ref_in);
            cur_q.pre  <= 1'b1;
            cur_q.post <= POST_HIGH;
            cur_q.mul  <= '0;
        end else if (step && !last) begin
            if (!sweep_end) begin
                cur_q.mul <= cur_q.mul + 1'b1;
                acc_q     <= acc_q + ACC_W'(ref_q);
            end else begin
                cur_q.mul <= '0;
                acc_q     <= ACC_W'(ref_q);
                if (cur_q.post != '0) begin
                    cur_q.post <= cur_q.post - 1'b1;
                end else begin
                    cur_q.pre  <= 1'b0;
                    cur_q.post <= POST_HIGH;
                end
            end
        end
    end

    assign cur = cur_q;

    // R1: the running product always equals ref*(mul+1).
    a_r1_acc_product: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q == ACC_W'(ref_q) * ACC_W'({1'b0, cur_q.mul} + 9'd1));

    // R2: a sweep step moves mul upward by exactly one inside a group.
    a_r2_mul_upward: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !sweep_end) |=> (cur_q.mul != '0));

endmodule

// File: rtl/pllsrch_best.sv
// Best-result tracker.
// Evaluates one trial per cycle against the target. Trials above the
// target are rejected and reported as 'over'. Among the rest, only a
// strictly smaller error replaces the stored best, so ties keep the
// earliest. 'hit' flags a trial equal to the target in the current cycle.
module pllsrch_best
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W  = 24,
    localparam int ACC_W  = FREQ_W + MUL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              eval,
    input  logic [ACC_W-1:0]  trial,
    input  logic [FREQ_W-1:0] target,
    input  pll_set_t          cur,
    output logic              over,
    output logic              hit,
    output logic              best_valid,
    output pll_set_t          best_set,
    output logic [FREQ_W-1:0] best_freq
);

    logic              valid_q;
    pll_set_t          set_q;
    logic [FREQ_W-1:0] freq_q;
    logic [FREQ_W-1:0] err_q;
    logic [FREQ_W-1:0] err;
    logic              take;

    // Overshoot test, error and replacement decision for this trial.
    always_comb begin
        over = trial > ACC_W'(target);
        err  = target - trial[FREQ_W-1:0];
        hit  = eval && !over && (err == '0);
        take = eval && !over && (!valid_q || (err < err_q));
    end

    // Hold the best setting seen since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            valid_q <= 1'b0;
            set_q   <= '0;
            freq_q  <= '0;
            err_q   <= '1;
        end else if (take) begin
            valid_q <= 1'b1;
            set_q   <= cur;
            freq_q  <= trial[FREQ_W-1:0];
            err_q   <= err;
        end
    end

    assign best_valid = valid_q;
    assign best_set   = set_q;
    assign best_freq  = freq_q;

    // R3: a stored result never lies above the target.
    a_r3_best_below: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (freq_q <= target));

    // R3: within one search the stored error never grows.
    a_r3_err_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clear) |=> (err_q <= $past(err_q)));

endmodule

// File: rtl/pllsrch_filter.sv
// Loop-filter band selection.
// Pure combinational: takes the reference in whole MHz and the chosen
// pre-divider bit, forms the pre-divided frequency and maps it to a band
// code and an out-of-range warning.
module pllsrch_filter
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W = 24
) (
    input  logic [FREQ_W-1:0] ref_mhz,
    input  logic              pre,
    output logic [FLT_W-1:0]  code,
    output logic              warn
);

    localparam int LOW_MHZ  = 10;
    localparam int HIGH_MHZ = 200;

    logic [FREQ_W-1:0] pd_mhz;

    // Band lookup on the pre-divided MHz value.
    always_comb begin
        pd_mhz = ref_mhz >> pre;
        if (pd_mhz >= FREQ_W'(166))      code = 3'd7;
        else if (pd_mhz >= FREQ_W'(104)) code = 3'd6;
        else if (pd_mhz >= FREQ_W'(65))  code = 3'd5;
        else if (pd_mhz >= FREQ_W'(42))  code = 3'd4;
        else if (pd_mhz >= FREQ_W'(26))  code = 3'd3;
        else if (pd_mhz >= FREQ_W'(16))  code = 3'd2;
        else if (pd_mhz >= FREQ_W'(LOW_MHZ)) code = 3'd1;
        else                             code = 3'd0;
        warn = (pd_mhz < FREQ_W'(LOW_MHZ)) || (pd_mhz > FREQ_W'(HIGH_MHZ));
    end

endmodule

// File: rtl/pllsrch_engine.sv
// PLL setting search engine, top level.
// Sequence: accept start, convert the reference to MHz, walk all settings
// one per cycle tracking the best, then pack the result and pulse done.
// Assumes start is sampled only while idle; results hold until the next
// completion.
module pllsrch_engine
    import pllsrch_pkg::*;
#(
    parameter int FREQ_W      = 24,
    parameter int KHZ_PER_MHZ = 1000,
    localparam int ACC_W      = FREQ_W + MUL_W + 1,
    localparam int REM_W      = $clog2(KHZ_PER_MHZ + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_khz,
    input  logic [FREQ_W-1:0] target_khz,
    output logic              busy,
    output logic              done,
    output logic [31:0]       cfg_word,
    output logic [FREQ_W-1:0] freq_khz,
    output logic              exact,
    output logic              range_warn,
    output logic              no_solution
);

    eng_state_t        state_q;
    logic [FREQ_W-1:0] tgt_q;
    logic              accept;
    logic              scanning;

    logic              div_busy;
    logic              div_done;
    logic [FREQ_W-1:0] ref_mhz;
    logic [REM_W-1:0]  div_rem;

    pll_set_t          cur;
    logic [ACC_W-1:0]  trial;
    logic              walk_last;

    logic              over;
    logic              hit;
    logic              best_valid;
    pll_set_t          best_set;
    logic [FREQ_W-1:0] best_freq;

    logic [FLT_W-1:0]  flt_code;
    logic              flt_warn;

    logic              done_q;
    logic [31:0]       cfg_q;
    logic [FREQ_W-1:0] freq_q;
    logic              exact_q;
    logic              warn_q;
    logic              nosol_q;

    // Handshake decode.
    always_comb begin
        accept   = (state_q == ST_IDLE) && start;
        scanning = (state_q == ST_SCAN);
    end

    pllsrch_div #(
        .W       (FREQ_W),
        .DIVISOR (KHZ_PER_MHZ)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .dividend  (ref_khz),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (ref_mhz),
        .remainder (div_rem)
    );

    pllsrch_walker #(
        .FREQ_W (FREQ_W)
    ) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (scanning),
        .skip   (over),
        .ref_in (ref_khz),
        .cur    (cur),
        .trial  (trial),
        .last   (walk_last)
    );

    pllsrch_best #(
        .FREQ_W (FREQ_W)
    ) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .eval       (scanning),
        .trial      (trial),
        .target     (tgt_q),
        .cur        (cur),
        .over       (over),
        .hit        (hit),
        .best_valid (best_valid),
        .best_set   (best_set),
        .best_freq  (best_freq)
    );

    pllsrch_filter #(
        .FREQ_W (FREQ_W)
    ) u_flt (
        .ref_mhz (ref_mhz),
        .pre     (best_set.pre),
        .code    (flt_code),
        .warn    (flt_warn)
    );

    // Search sequencing and target capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    tgt_q   <= target_khz;
                    state_q <= ST_CONV;
                end
                ST_CONV: if (div_done) state_q <= ST_SCAN;
                ST_SCAN: if (hit || walk_last) state_q <= ST_WRAP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers, loaded once per search on the wrap-up cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            cfg_q   <= '0;
            freq_q  <= '0;
            exact_q <= 1'b0;
            warn_q  <= 1'b0;
            nosol_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_WRAP);
            if (state_q == ST_WRAP) begin
                if (best_valid) begin
                    cfg_q   <= pack_cfg(flt_code, best_set);
                    freq_q  <= best_freq;
                    exact_q <= (best_freq == tgt_q);
                    warn_q  <= flt_warn;
                    nosol_q <= 1'b0;
                end else begin
                    cfg_q   <= '0;
                    freq_q  <= '0;
                    exact_q <= 1'b0;
                    warn_q  <= 1'b0;
                    nosol_q <= 1'b1;
                end
            end
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign cfg_word    = cfg_q;
    assign freq_khz    = freq_q;
    assign exact       = exact_q;
    assign range_warn  = warn_q;
    assign no_solution = nosol_q;

    // R9: completion is a single-cycle pulse.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: no-solution results carry an all-zero word and frequency.
    a_r8_nosol_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nosol_q |-> ((cfg_q == '0) && (freq_q == '0) && !exact_q && !warn_q));

    // R4: an exact result reports the captured target as its frequency.
    a_r4_exact_freq: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && exact_q) |-> (freq_q == tgt_q));

    // R10: a start while busy leaves the captured target untouched.
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_q));

    // R9: the conversion never runs during the setting walk.
    a_r9_conv_before_scan: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> !div_busy);

endmodule

// File: tb/tb_pllsrch_engine.sv
// Scoreboard bench: the driver pushes the expected result of each request,
// and the monitor pops and compares on every done pulse.
module tb_pllsrch_engine;

    localparam int FREQ_W = 24;

    typedef struct {
        logic [31:0]       word;
        logic [FREQ_W-1:0] freq;
        logic              exact;
        logic              warn;
        logic              nosol;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [FREQ_W-1:0] ref_khz = '0;
    logic [FREQ_W-1:0] target_khz = '0;
    logic              busy;
    logic              done;
    logic [31:0]       cfg_word;
    logic [FREQ_W-1:0] freq_khz;
    logic              exact;
    logic              range_warn;
    logic              no_solution;

    int   n_checks = 0;
    int   n_fail = 0;
    int   n_done = 0;
    int   n_pushed = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    pllsrch_engine #(.FREQ_W(FREQ_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ref_khz     (ref_khz),
        .target_khz  (target_khz),
        .busy        (busy),
        .done        (done),
        .cfg_word    (cfg_word),
        .freq_khz    (freq_khz),
        .exact       (exact),
        .range_warn  (range_warn),
        .no_solution (no_solution)
    );

    always #5 clk = ~clk;

    task automatic check(bit ok, string req, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // Expected result computed straight from the requirements.
    function automatic exp_t model(longint r, longint t);
        exp_t   e;
        bit     have = 0;
        bit     found = 0;
        longint be = 0;
        longint bf = 0;
        int     bp = 0, bq = 0, bm = 0;
        longint mhz, pd;
        int     code;
        for (int p = 1; p >= 0 && !found; p--)            // R2 order
            for (int q = 7; q >= 0 && !found; q--)
                for (int m = 0; m <= 255 && !found; m++) begin
                    longint tr = (r * (m + 1)) / ((p + 1) * (longint'(1) << q)); // R1
                    if (tr <= t) begin                     // R3
                        longint er = t - tr;
                        if (!have || er < be) begin
                            have = 1; be = er; bf = tr; bp = p; bq = q; bm = m;
                        end
                        if (er == 0) found = 1;            // R4
                    end
                end
        if (!have) begin                                   // R8
            e.word = '0; e.freq = '0; e.exact = 0; e.warn = 0; e.nosol = 1;
            return e;
        end
        mhz = r / 1000;
        pd  = mhz / (bp + 1);                               // R5
        if (pd >= 166)      code = 7;
        else if (pd >= 104) code = 6;
        else if (pd >= 65)  code = 5;
        else if (pd >= 42)  code = 4;
        else if (pd >= 26)  code = 3;
        else if (pd >= 16)  code = 2;
        else if (pd >= 10)  code = 1;
        else                code = 0;
        e.word  = {8'(code), 8'(bm), 7'b0, 1'(bp), 5'b0, 3'(bq)}; // R7
        e.freq  = FREQ_W'(bf);
        e.exact = found;
        e.warn  = (pd < 10) || (pd > 200);                 // R6
        e.nosol = 0;
        return e;
    endfunction

    // Driver: push the expectation, pulse start, wait for the result.
    task automatic run(longint r, longint t);
        exp_t e;
        e = model(r, t);
        @(negedge clk);
        while (busy) @(negedge clk);
        sb_q.push_back(e);
        n_pushed++;
        ref_khz = FREQ_W'(r);
        target_khz = FREQ_W'(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done < n_pushed) @(negedge clk);
    endtask

    // Monitor: compare every completion against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb_q.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last_exp = e;
                check(cfg_word == e.word, "R5/R7 cfg_word", cfg_word, e.word);
                check(freq_khz == e.freq, "R1/R2/R3 freq_khz", freq_khz, e.freq);
                check(exact == e.exact, "R4 exact", exact, e.exact);
                check(range_warn == e.warn, "R6 range_warn", range_warn, e.warn);
                check(no_solution == e.nosol, "R8 no_solution", no_solution, e.nosol);
            end
        end
    end

    // Single-cycle done pulse and busy while running (R9).
    always @(negedge clk) begin
        if (rst_n && done) begin
            @(negedge clk);
            check(!done, "R9 done width", done, 0);
            check(!busy, "R9 busy after done", busy, 0);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check(!busy && !done, "R11 reset handshake", {busy, done}, 0);
        check(cfg_word == 0 && freq_khz == 0, "R11 reset word", cfg_word, 0);
        check(!exact && !range_warn && !no_solution, "R11 reset flags",
              {exact, range_warn, no_solution}, 0);

        run(25000, 800000);     // R4 exact, found in a middle group
        run(200000, 200000);    // R2 exact at first reachable setting
        run(24000, 1000001);    // R3 inexact full walk
        run(27000, 999999);     // R2 ties resolved by order
        run(25600, 50);         // R8 every setting overshoots
        run(1000, 0);           // R8 zero target
        run(450000, 3000000);   // R6 high warning, R5 top band
        run(8000, 123457);      // R6 low warning, R5 band 0
        run(66000, 500003);     // R5 band edges
        run(33000, 777777);
        run(90000, 1600000);
        run(120000, 65535);
        run(12000, 333333);

        // R9: busy is asserted while a search runs.
        e = model(19200, 480000);
        @(negedge clk);
        sb_q.push_back(e);
        n_pushed++;
        ref_khz = FREQ_W'(19200);
        target_khz = FREQ_W'(480000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 busy after start", busy, 1);
        // R10: a second start during the search is ignored.
        repeat (40) @(negedge clk);
        ref_khz = FREQ_W'(50000);
        target_khz = FREQ_W'(7);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done < n_pushed) @(negedge clk);
        repeat (6000) @(negedge clk);
        check(n_done == n_pushed, "R10 done count", n_done, n_pushed);
        check(sb_q.size() == 0, "R10 scoreboard drained", sb_q.size(), 0);

        // R11: outputs still hold the last result.
        check(cfg_word == last_exp.word, "R11 hold word", cfg_word, last_exp.word);
        check(freq_khz == last_exp.freq, "R11 hold freq", freq_khz, last_exp.freq);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule